// File: doc/BRIEF.md
# Configuration Status Interrupt Monitor

This block observes twelve status lines coming back from a device under configuration and turns them into a single interrupt request. Each line has its own configuration: an enable, a mask, a choice between level and edge triggering, and an active polarity. Software reaches the block through a simple 32-bit register port. Through that port it can read the raw status (detected conditions gated by enable) and the masked status (what actually drives the interrupt). It can acknowledge latched edge events and sample the present, synchronized state of the lines.

The line positions are fixed by the device:
- bit 11: power-on indication.
- bits 10, 9, 8: pin-level done, status and config signals.
- bits 7, 6, 5: partial reconfiguration done, error and ready.
- bit 4: done flag of an alternate configuration path.
- bit 3: CRC error.
- bit 2: init done.
- bit 1: configuration done.
- bit 0: status.

Every line passes through a two-flop synchronizer before it is used anywhere.

A typical use is to arm only the configuration-done line, choose level triggering with active-high polarity, and wait for the interrupt. An edge-triggered line holds its event until software writes a 1 to that bit of the acknowledge register.

Top module: `stat_irq_monitor`

## Requirements
- R1: After reset, the enable, mask, trigger-type and polarity registers (offsets 0x830, 0x834, 0x838, 0x83C) and both status views read 0, and the interrupt output is low.
- R2: A write to a configuration register stores bits 11:0 of the write data. A read returns those bits with bits 31:12 at zero.
- R3: A read at offset 0x850 returns the line values through two flops. A change at the input first appears on the second rising clock edge after it is applied.
- R4: A bit whose trigger-type bit is 0 is level-sensitive. Its raw status (offset 0x844) is 1 while its input equals its polarity bit (1 = active high, 0 = active low), and a write to the acknowledge register does not clear it.
- R5: A bit whose trigger-type bit is 1 latches an event on an input transition toward its active level (a rising edge for polarity 1, a falling edge for polarity 0). The event stays set after the input returns.
- R6: Writing 1 to a bit of the acknowledge register (offset 0x84C) clears that bit's latched event, and writing 0 leaves it. When a new edge and an acknowledge meet in the same cycle, the event stays set.
- R7: A bit whose enable bit is 0 shows 0 in the raw status and latches no event.
- R8: The masked status (offset 0x840) is the raw status with every bit whose mask bit is 1 forced to 0.
- R9: The interrupt output is high exactly when some masked status bit is 1.
- R10: Writes to offsets 0x840, 0x844 and 0x850, and to unmapped offsets, change no register. A read of offset 0x84C returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 12 | Status lines from the device, asynchronous |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the offset |
| irq_o | output | 1 | Interrupt request, OR of the masked status |

## Verification
A register write takes effect at the clock edge that samples the strobe, and a read reflects the stored state within the same cycle.

A line change reaches the live read and any level-sensitive status on the second rising edge. An edge event needs one more edge for the history flop, so it is latched on the third.

The bench changes lines on falling edges and waits three falling edges before sampling the status views and the interrupt. It probes the live read one and two edges after a change to pin down the synchronizer delay. The same-cycle acknowledge case is built by aligning the write strobe with the third edge after a line change.

// File: rtl/stmon_pkg.sv
package stmon_pkg;

    // Register byte offsets decoded by software drivers.
    localparam int unsigned OFS_ENABLE = 32'h830;
    localparam int unsigned OFS_MASK   = 32'h834;
    localparam int unsigned OFS_TRIG   = 32'h838;
    localparam int unsigned OFS_POLAR  = 32'h83C;
    localparam int unsigned OFS_MSTAT  = 32'h840;
    localparam int unsigned OFS_RSTAT  = 32'h844;
    localparam int unsigned OFS_ACK    = 32'h84C;
    localparam int unsigned OFS_LIVE   = 32'h850;

endpackage

// File: rtl/stmon_sync.sv
module stmon_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = async_i;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.sync;

endmodule

// File: rtl/stmon_cfg.sv
module stmon_cfg
    import stmon_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [W-1:0]  en_o,
    output logic [W-1:0]  mask_o,
    output logic [W-1:0]  trig_o,
    output logic [W-1:0]  pol_o,
    output logic [W-1:0]  ack_o
);

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] mask;
        logic [W-1:0] trig;
        logic [W-1:0] pol;
    } cfg_t;

    cfg_t c_d, c_q;
    logic [W-1:0] ack_d;
    logic [W-1:0] wfield;
    logic         unused_wdata_hi;

    assign wfield          = wdata_i[W-1:0];
    assign unused_wdata_hi = ^wdata_i[DW-1:W];

    always_comb begin
        c_d   = c_q;
        ack_d = '0;
        if (wr_i) begin
            case (addr_i)
                AW'(OFS_ENABLE): c_d.en   = wfield;
                AW'(OFS_MASK):   c_d.mask = wfield;
                AW'(OFS_TRIG):   c_d.trig = wfield;
                AW'(OFS_POLAR):  c_d.pol  = wfield;
                AW'(OFS_ACK):    ack_d    = wfield;
                default:         ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign en_o   = c_q.en;
    assign mask_o = c_q.mask;
    assign trig_o = c_q.trig;
    assign pol_o  = c_q.pol;
    assign ack_o  = ack_d;

endmodule

// File: rtl/stmon_detect.sv
module stmon_detect #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] trig_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] evt_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] evt;
    } det_t;

    det_t d_d, d_q;
    logic [W-1:0] set_w;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic rise_w;
        logic fall_w;
        logic lvl_w;
        assign rise_w   = line_i[g] & ~d_q.prev[g];
        assign fall_w   = ~line_i[g] & d_q.prev[g];
        assign lvl_w    = pol_i[g] ? line_i[g] : ~line_i[g];
        assign set_w[g] = en_i[g] & trig_i[g] & (pol_i[g] ? rise_w : fall_w);
        assign raw_o[g] = en_i[g] & (trig_i[g] ? d_q.evt[g] : lvl_w);
    end

    always_comb begin
        d_d      = d_q;
        d_d.prev = line_i;
        // a fresh edge outranks an acknowledge in the same cycle
        d_d.evt  = (d_q.evt & ~ack_i) | set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign evt_o = d_q.evt;

endmodule

// File: rtl/stat_irq_monitor.sv
module stat_irq_monitor
    import stmon_pkg::*;
#(
    parameter int unsigned N_LINES = 12,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LINES-1:0] line_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic [N_LINES-1:0] live_w;
    logic [N_LINES-1:0] en_w;
    logic [N_LINES-1:0] mask_w;
    logic [N_LINES-1:0] trig_w;
    logic [N_LINES-1:0] pol_w;
    logic [N_LINES-1:0] ack_w;
    logic [N_LINES-1:0] raw_w;
    logic [N_LINES-1:0] evt_w;
    logic [N_LINES-1:0] masked_w;
    logic [DATA_W-1:0]  rd_w;

    stmon_sync #(.W(N_LINES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (live_w)
    );

    stmon_cfg #(.W(N_LINES), .AW(ADDR_W), .DW(DATA_W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .en_o    (en_w),
        .mask_o  (mask_w),
        .trig_o  (trig_w),
        .pol_o   (pol_w),
        .ack_o   (ack_w)
    );

    stmon_detect #(.W(N_LINES)) i_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (live_w),
        .en_i    (en_w),
        .trig_i  (trig_w),
        .pol_i   (pol_w),
        .ack_i   (ack_w),
        .raw_o   (raw_w),
        .evt_o   (evt_w)
    );

    assign masked_w = raw_w & ~mask_w;
    assign irq_o    = |masked_w;

    always_comb begin
        rd_w = '0;
        case (bus_addr_i)
            ADDR_W'(OFS_ENABLE): rd_w = DATA_W'(en_w);
            ADDR_W'(OFS_MASK):   rd_w = DATA_W'(mask_w);
            ADDR_W'(OFS_TRIG):   rd_w = DATA_W'(trig_w);
            ADDR_W'(OFS_POLAR):  rd_w = DATA_W'(pol_w);
            ADDR_W'(OFS_MSTAT):  rd_w = DATA_W'(masked_w);
            ADDR_W'(OFS_RSTAT):  rd_w = DATA_W'(raw_w);
            ADDR_W'(OFS_LIVE):   rd_w = DATA_W'(live_w);
            default:             rd_w = '0;
        endcase
    end

    assign bus_rdata_o = rd_w;

endmodule

// File: rtl/stmon_checks.sv
module stmon_checks
    import stmon_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  line_i,
    input logic          bus_wr_i,
    input logic [AW-1:0] bus_addr_i,
    input logic [DW-1:0] bus_wdata_i,
    input logic          irq_o,
    input logic [W-1:0]  en_w,
    input logic [W-1:0]  mask_w,
    input logic [W-1:0]  raw_w,
    input logic [W-1:0]  masked_w,
    input logic [W-1:0]  evt_w,
    input logic [W-1:0]  live_w
);

    logic [1:0]   age_q;
    logic [W-1:0] hold_q;
    logic [W-1:0] clr_w;
    logic         unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i[DW-1:W];
    assign clr_w = (bus_wr_i && bus_addr_i == AW'(OFS_ACK)) ? bus_wdata_i[W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q  <= '0;
            hold_q <= '0;
        end else begin
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
            hold_q <= evt_w & ~clr_w;
        end
    end

    // R3: the live view trails the pins by two edges
    a_r3_live_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (live_w == $past(line_i, 2)));

    // R5, R6: a latched event survives unless acknowledged
    a_r5_event_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_q & ~evt_w) == '0));

    // R7: disabled bits never show raw status
    a_r7_raw_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_w & ~en_w) == '0));

    // R8: masked bits never reach the masked view
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_w & mask_w) == '0));

    // R9: an interrupt needs an unmasked raw source
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw_w & ~mask_w) != '0));

    // R9: no interrupt while the masked view is empty
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (masked_w == '0));

endmodule

bind stat_irq_monitor stmon_checks #(.W(N_LINES), .AW(ADDR_W), .DW(DATA_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (line_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .en_w        (en_w),
    .mask_w      (mask_w),
    .raw_w       (raw_w),
    .masked_w    (masked_w),
    .evt_w       (evt_w),
    .live_w      (live_w)
);

// File: tb/test_stat_irq_monitor.sv
`timescale 1ns/1ps
module test_stat_irq_monitor;

    localparam logic [11:0] A_EN   = 12'h830;
    localparam logic [11:0] A_MASK = 12'h834;
    localparam logic [11:0] A_TRIG = 12'h838;
    localparam logic [11:0] A_POL  = 12'h83C;
    localparam logic [11:0] A_MST  = 12'h840;
    localparam logic [11:0] A_RST  = 12'h844;
    localparam logic [11:0] A_ACK  = 12'h84C;
    localparam logic [11:0] A_LIVE = 12'h850;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] line = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [11:0] m_en = '0, m_mask = '0, m_trig = '0, m_pol = '0, m_evt = '0, m_line = '0;

    always #2 clk = ~clk;

    stat_irq_monitor i_stat_irq_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [11:0] exp_raw();
        return m_en & ((~m_trig & ~(m_line ^ m_pol)) | (m_trig & m_evt));
    endfunction

    task automatic apply_lines(input logic [11:0] nv);
        logic [11:0] rise, fall;
        rise  = nv & ~m_line;
        fall  = ~nv & m_line;
        m_evt = m_evt | (m_en & m_trig & ((m_pol & rise) | (~m_pol & fall)));
        m_line = nv;
        @(negedge clk);
        line = nv;
        repeat (3) @(negedge clk);
    endtask

    task automatic configure(input logic [11:0] en, input logic [11:0] mk,
                             input logic [11:0] tr, input logic [11:0] pl);
        wr_reg(A_EN, {20'h0, en});   m_en = en;
        wr_reg(A_MASK, {20'h0, mk}); m_mask = mk;
        wr_reg(A_TRIG, {20'h0, tr}); m_trig = tr;
        wr_reg(A_POL, {20'h0, pl});  m_pol = pl;
        wr_reg(A_ACK, 32'hFFF);      m_evt = '0;
    endtask

    task automatic check_status(input string ctx);
        logic [31:0] v;
        logic [11:0] er;
        er = exp_raw();
        rd_reg(A_RST, v);
        check({"R4 R5 R7 raw ", ctx}, v, {20'h0, er});
        rd_reg(A_MST, v);
        check({"R8 masked ", ctx}, v, {20'h0, er & ~m_mask});
        check({"R9 irq ", ctx}, {31'h0, irq}, {31'h0, |(er & ~m_mask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] pat;
        logic [11:0] s_en, s_mk, s_tr, s_pl, s_raw, s_mst, s_live;
        logic [11:0] ackv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(A_EN, v);   check("R1 enable", v, 32'h0);
        rd_reg(A_MASK, v); check("R1 mask", v, 32'h0);
        rd_reg(A_TRIG, v); check("R1 trig", v, 32'h0);
        rd_reg(A_POL, v);  check("R1 pol", v, 32'h0);
        rd_reg(A_RST, v);  check("R1 raw", v, 32'h0);
        rd_reg(A_MST, v);  check("R1 masked", v, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2 write width and readback
        wr_reg(A_EN, 32'hFFFF_FFFF);   rd_reg(A_EN, v);   check("R2 enable", v, 32'hFFF);
        wr_reg(A_EN, 32'h0);           rd_reg(A_EN, v);   check("R2 enable clr", v, 32'h0);
        wr_reg(A_MASK, 32'hABCD_E123); rd_reg(A_MASK, v); check("R2 mask", v, 32'h123);
        wr_reg(A_MASK, 32'h0);
        wr_reg(A_TRIG, 32'h1234_5A5A); rd_reg(A_TRIG, v); check("R2 trig", v, 32'hA5A);
        wr_reg(A_TRIG, 32'h0);
        wr_reg(A_POL, 32'hFFFF_F3C6);  rd_reg(A_POL, v);  check("R2 pol", v, 32'h3C6);
        wr_reg(A_POL, 32'h0);

        // R3 synchronizer latency on the live view
        @(negedge clk);
        line = 12'h5A5;
        addr = A_LIVE; #1;
        check("R3 live same cycle", rdata, 32'h0);
        @(negedge clk); #1;
        check("R3 live one edge", rdata, 32'h0);
        @(negedge clk); #1;
        check("R3 live two edges", rdata, 32'h5A5);
        m_line = 12'h5A5;

        // R4..R9 sweep over uniform and mixed per-bit settings
        pat = 12'hA53;
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: configure(12'hFFF, 12'h000, 12'h000, 12'hFFF);
                1: configure(12'hFFF, 12'h000, 12'h000, 12'h000);
                2: configure(12'hFFF, 12'h000, 12'hFFF, 12'hFFF);
                3: configure(12'hFFF, 12'h000, 12'hFFF, 12'h000);
                4: configure(12'h0F3, 12'hA50, 12'h5A6, 12'h3C9);
                default: configure(12'hF0F, 12'h0FF, 12'hC3C, 12'h96A);
            endcase
            check_status("after config");
            for (int s = 0; s < 12; s++) begin
                pat = {pat[10:0], pat[11] ^ pat[10] ^ pat[9] ^ pat[3]};
                apply_lines(pat ^ {s[3:0], s[3:0], s[3:0]});
                check_status("after lines");
                if ((s % 3) == 2) begin
                    ackv = pat ^ 12'h5F0;
                    wr_reg(A_ACK, {20'h0, ackv});
                    m_evt = m_evt & ~ackv;
                    check_status("R6 after ack");
                end
            end
        end

        // R10 read-only and unmapped writes
        rd_reg(A_EN, v);   s_en = v[11:0];
        rd_reg(A_MASK, v); s_mk = v[11:0];
        rd_reg(A_TRIG, v); s_tr = v[11:0];
        rd_reg(A_POL, v);  s_pl = v[11:0];
        rd_reg(A_RST, v);  s_raw = v[11:0];
        rd_reg(A_MST, v);  s_mst = v[11:0];
        rd_reg(A_LIVE, v); s_live = v[11:0];
        wr_reg(A_MST, 32'hFFFF_FFFF);
        wr_reg(A_RST, 32'hFFFF_FFFF);
        wr_reg(A_LIVE, 32'hFFFF_FFFF);
        wr_reg(12'h800, 32'hFFFF_FFFF);
        rd_reg(A_EN, v);   check("R10 enable kept", v, {20'h0, s_en});
        rd_reg(A_MASK, v); check("R10 mask kept", v, {20'h0, s_mk});
        rd_reg(A_TRIG, v); check("R10 trig kept", v, {20'h0, s_tr});
        rd_reg(A_POL, v);  check("R10 pol kept", v, {20'h0, s_pl});
        rd_reg(A_RST, v);  check("R10 raw kept", v, {20'h0, s_raw});
        rd_reg(A_MST, v);  check("R10 masked kept", v, {20'h0, s_mst});
        rd_reg(A_LIVE, v); check("R10 live kept", v, {20'h0, s_live});
        rd_reg(A_ACK, v);  check("R10 ack reads zero", v, 32'h0);

        // R6 edge and acknowledge in the same cycle
        configure(12'hFFF, 12'h000, 12'hFFF, 12'hFFF);
        apply_lines(12'h000);
        m_evt = '0;
        wr_reg(A_ACK, 32'hFFF);
        check_status("R6 quiet");
        @(negedge clk);
        line = 12'h008;
        @(negedge clk);
        wr_reg(A_ACK, 32'h008);
        m_line = 12'h008;
        rd_reg(A_RST, v);
        check("R6 edge wins over ack", v, 32'h008);
        check("R9 irq on event", {31'h0, irq}, 32'h1);
        wr_reg(A_ACK, 32'h008);
        rd_reg(A_RST, v);
        check("R6 ack clears", v, 32'h0);
        check("R9 irq after ack", {31'h0, irq}, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule